// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This execution unit takes two 32-bit operands and an operation code and returns a registered 32-bit result one cycle later, with a valid strobe. The operation works on the whole word, on two 16-bit halves, or on four 8-bit bytes. In the packed modes every lane computes in parallel and saturates on its own signed range. The available operations are add, subtract and absolute value, each with a wrapping form and a saturating form. There is also a left shift of paired halves, whose amount comes from an immediate or from the second operand.

A small control register sits beside the datapath. It holds a carry bit and four sticky per-lane overflow flags. A carry-producing add stores its carry-out there. A following add-with-carry consumes it, so a low-word add and then a high-word add build a 64-bit sum. The flags collect every lane clamp until software overwrites the register through a dedicated write port.

Top module: `simd_sat_alu`

## Requirements
- R1: While reset is held, and at the first edge after it, `out_valid`, `result`, `ctl_carry` and `ctl_ovf` are all zero.
- R2: An operation presented with `in_valid` high appears on `result`, with `out_valid` high, after exactly one rising edge. `out_valid` is low after any cycle without `in_valid`, and `result` then holds its value.
- R3: For `op_kind` 0 (add) and 1 (subtract) with `lane_mode` 0 (whole word), the wrapping form (`sat_en`=0) returns the low 32 bits. The saturating form clamps to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R4: With `lane_mode` 1 (paired halves, lane 0 = bits 15:0), add and subtract act on each half independently. In the saturating form each half clamps to 0x7FFF or 0x8000 without affecting the other half.
- R5: With `lane_mode` 2 (four bytes, lane i = bits 8i+7:8i), add and subtract act on each byte independently. In the saturating form each byte clamps to 0x7F or 0x80.
- R6: `op_kind` 2 (absolute value) negates negative lanes in the selected lane mode. The most negative lane value becomes the most positive value in the saturating form and is returned unchanged in the wrapping form.
- R7: `op_kind` 3 shifts both 16-bit halves of `op_a` left by `shamt_imm`. `op_kind` 4 shifts them by `op_b[3:0]`. The upper bits of `op_b` are ignored. A shift by zero returns `op_a`.
- R8: In the saturating form of either shift, a half whose shifted value leaves the signed 16-bit range becomes 0x7FFF if it was non-negative and 0x8000 if it was negative. The wrapping form keeps the low 16 bits.
- R9: `op_kind` 5 returns the wrapped 32-bit sum of the operands and stores its carry-out into `ctl_carry`. No other operation changes `ctl_carry`.
- R10: `op_kind` 6 returns `op_a + op_b + ctl_carry`, wrapped. Issued in the cycle right after an `op_kind` 5, it uses that operation's carry, so the pair forms a 64-bit sum.
- R11: When a saturating operation clamps lane i (the whole word counts as lane 0, halves as lanes 0 and 1), `ctl_ovf[i]` is set in the cycle the result becomes valid. The bit stays set; wrapping operations never set a flag.
- R12: `ctl_wr_en` loads `ctl_wr_data` (bit 0 to the carry, bits 4:1 to `ctl_ovf[3:0]`) at the next edge. This write takes priority over any flag or carry update at the same edge, and it is the only way to clear a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation select (0 add, 1 sub, 2 abs, 3 shift imm, 4 shift reg, 5 carry add, 6 add with carry) |
| lane_mode | input | 2 | 0 word, 1 paired halves, 2 four bytes |
| sat_en | input | 1 | Selects the saturating form |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand or shift amount |
| shamt_imm | input | 4 | Immediate shift amount |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 5 | Control register write value |
| out_valid | output | 1 | Result valid strobe |
| result | output | 32 | Registered result |
| ctl_carry | output | 1 | Stored carry bit |
| ctl_ovf | output | 4 | Sticky per-lane overflow flags |

## Verification
Whole-word operands sitting exactly at the signed limits show apart the wrapping and saturating forms and the sign of the clamp. Packed operands that overflow in one lane only, with neighbouring lanes that do not, reveal any carry or clamp leaking across lane boundaries, and reveal which flag bit is set. Shift patterns are chosen so that one half clamps negative and the other stays in range, and register-supplied amounts carry junk in the upper bits. A back-to-back carry add followed by an add with carry, with a carry out of the low word, checks that the stored carry reaches the very next operation. A control write in the same cycle as a clamping operation checks the write priority.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [2:0] {
    K_ADD     = 3'd0,
    K_SUB     = 3'd1,
    K_ABS     = 3'd2,
    K_SHL_IMM = 3'd3,
    K_SHL_REG = 3'd4,
    K_ADDC    = 3'd5,
    K_ADDWC   = 3'd6,
    K_RSVD    = 3'd7
  } op_kind_e;

  typedef enum logic [1:0] {
    LM_WORD = 2'd0,
    LM_PAIR = 2'd1,
    LM_QUAD = 2'd2,
    LM_RSVD = 2'd3
  } lane_mode_e;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_ABS = 2'd2;

  function automatic logic [1:0] kind_to_fn(op_kind_e k);
    case (k)
      K_SUB:   return FN_SUB;
      K_ABS:   return FN_ABS;
      default: return FN_ADD;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  input  logic         sat,
  output logic [W-1:0] res,
  output logic         clamp
);
  import simd_alu_pkg::*;

  logic signed [W:0] ext_a, ext_b, wide;
  logic              ovf_raw;
  logic [W-1:0]      lim_pos, lim_neg, sum_w;

  assign lim_pos = {1'b0, {(W-1){1'b1}}};
  assign lim_neg = {1'b1, {(W-1){1'b0}}};
  assign sum_w   = a + b;

  always_comb begin
    ext_a = {a[W-1], a};
    ext_b = {b[W-1], b};
    case (fn)
      FN_ADD:  wide = ext_a + ext_b;
      FN_SUB:  wide = ext_a - ext_b;
      default: wide = a[W-1] ? -ext_a : ext_a;
    endcase
  end

  assign ovf_raw = wide[W] ^ wide[W-1];
  assign clamp   = sat & ovf_raw;
  assign res     = clamp ? (wide[W] ? lim_neg : lim_pos) : wide[W-1:0];

  always_comb begin
    // R3
    if (fn == FN_ADD && !sat) add_wrap_chk: assert (res == sum_w);
    // R4
    if (clamp && fn != FN_ABS) clamp_sign_chk: assert (res[W-1] == a[W-1]);
    // R6
    if (clamp && fn == FN_ABS) abs_clamp_chk: assert (res == lim_pos);
  end

endmodule

// File: rtl/simd_ph_shift.sv
module simd_ph_shift #(
  parameter int HALF_W  = 16,
  parameter int HALVES  = 2,
  parameter int SHAMT_W = 4
) (
  input  logic [HALF_W*HALVES-1:0] a,
  input  logic [SHAMT_W-1:0]       amt,
  input  logic                     sat,
  output logic [HALF_W*HALVES-1:0] res,
  output logic [HALVES-1:0]        clamp
);
  localparam int PW = 2 * HALF_W;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] src;
    logic [PW-1:0]     wide;
    logic [HALF_W:0]   upper;
    logic              out_of_range;

    assign src          = a[h*HALF_W +: HALF_W];
    assign wide         = {{HALF_W{src[HALF_W-1]}}, src} << amt;
    assign upper        = wide[PW-1:HALF_W-1];
    assign out_of_range = !((&upper) || !(|upper));
    assign clamp[h]     = sat & out_of_range;
    assign res[h*HALF_W +: HALF_W] = clamp[h]
      ? (src[HALF_W-1] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}})
      : wide[HALF_W-1:0];
  end

  always_comb begin
    // R7
    if (amt == '0) zero_shift_chk: assert (res == a);
  end

endmodule

// File: rtl/simd_ctl_reg.sv
module simd_ctl_reg #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES:0]   wr_data,
  input  logic             upd_en,
  input  logic [LANES-1:0] set_ovf,
  input  logic             carry_we,
  input  logic             carry_in,
  output logic             carry_q,
  output logic [LANES-1:0] ovf_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      ovf_q   <= '0;
    end else if (wr_en) begin
      carry_q <= wr_data[0];
      ovf_q   <= wr_data[LANES:1];
    end else if (upd_en) begin
      ovf_q <= ovf_q | set_ovf;
      if (carry_we) carry_q <= carry_in;
    end
  end

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(upd_en && carry_we)) |=> $stable(carry_q));

  // R12
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({ovf_q, carry_q} == $past(wr_data)));

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_kind,
  input  logic [1:0]        lane_mode,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SHAMT_W-1:0] shamt_imm,
  input  logic              ctl_wr_en,
  input  logic [4:0]        ctl_wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ctl_carry,
  output logic [3:0]        ctl_ovf
);
  import simd_alu_pkg::*;

  localparam int LANES  = 4;
  localparam int N_HALF = 2;
  localparam int HALF_W = DATA_W / N_HALF;
  localparam int BYTE_W = DATA_W / LANES;

  op_kind_e   kind;
  lane_mode_e mode;
  logic [1:0] fn;

  assign kind = op_kind_e'(op_kind);
  assign mode = lane_mode_e'(lane_mode);
  assign fn   = kind_to_fn(kind);

  // whole-word lane
  logic [DATA_W-1:0] word_res;
  logic              word_clamp;

  simd_lane_arith #(.W(DATA_W)) u_word (
    .a(op_a), .b(op_b), .fn(fn), .sat(sat_en),
    .res(word_res), .clamp(word_clamp)
  );

  // paired-half lanes
  logic [DATA_W-1:0] pair_res;
  logic [N_HALF-1:0] pair_clamp;

  for (genvar h = 0; h < N_HALF; h++) begin : g_pair
    simd_lane_arith #(.W(HALF_W)) u_half (
      .a(op_a[h*HALF_W +: HALF_W]), .b(op_b[h*HALF_W +: HALF_W]),
      .fn(fn), .sat(sat_en),
      .res(pair_res[h*HALF_W +: HALF_W]), .clamp(pair_clamp[h])
    );
  end

  // quad-byte lanes
  logic [DATA_W-1:0] quad_res;
  logic [LANES-1:0]  quad_clamp;

  for (genvar q = 0; q < LANES; q++) begin : g_quad
    simd_lane_arith #(.W(BYTE_W)) u_byte (
      .a(op_a[q*BYTE_W +: BYTE_W]), .b(op_b[q*BYTE_W +: BYTE_W]),
      .fn(fn), .sat(sat_en),
      .res(quad_res[q*BYTE_W +: BYTE_W]), .clamp(quad_clamp[q])
    );
  end

  // paired-half shifter
  logic [SHAMT_W-1:0] shift_amt;
  logic [DATA_W-1:0]  shift_res;
  logic [N_HALF-1:0]  shift_clamp;

  assign shift_amt = (kind == K_SHL_REG) ? op_b[SHAMT_W-1:0] : shamt_imm;

  simd_ph_shift #(.HALF_W(HALF_W), .HALVES(N_HALF), .SHAMT_W(SHAMT_W)) u_shift (
    .a(op_a), .amt(shift_amt), .sat(sat_en),
    .res(shift_res), .clamp(shift_clamp)
  );

  // carry chain adders
  logic [DATA_W:0] addc_sum;
  logic [DATA_W:0] addwc_sum;
  logic            carry_out;

  assign addc_sum  = {1'b0, op_a} + {1'b0, op_b};
  assign addwc_sum = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, ctl_carry};
  assign carry_out = addc_sum[DATA_W];

  // result and lane clamp select
  logic [DATA_W-1:0] next_res;
  logic [LANES-1:0]  lane_clamp;
  logic              carry_we;

  assign carry_we = (kind == K_ADDC);

  always_comb begin
    next_res   = '0;
    lane_clamp = '0;
    case (kind)
      K_ADD, K_SUB, K_ABS: begin
        case (mode)
          LM_PAIR: begin
            next_res   = pair_res;
            lane_clamp = {{(LANES-N_HALF){1'b0}}, pair_clamp};
          end
          LM_QUAD: begin
            next_res   = quad_res;
            lane_clamp = quad_clamp;
          end
          default: begin
            next_res   = word_res;
            lane_clamp = {{(LANES-1){1'b0}}, word_clamp};
          end
        endcase
      end
      K_SHL_IMM, K_SHL_REG: begin
        next_res   = shift_res;
        lane_clamp = {{(LANES-N_HALF){1'b0}}, shift_clamp};
      end
      K_ADDC:  next_res = addc_sum[DATA_W-1:0];
      K_ADDWC: next_res = addwc_sum[DATA_W-1:0];
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  simd_ctl_reg #(.LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .upd_en(in_valid), .set_ovf(lane_clamp),
    .carry_we(carry_we), .carry_in(carry_out),
    .carry_q(ctl_carry), .ovf_q(ctl_ovf)
  );

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R11
  wrap_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en && !ctl_wr_en) |=> $stable(ctl_ovf));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0 && !ctl_carry && ctl_ovf == '0));

endmodule

// File: tb/sim_simd_sat_alu.sv
module sim_simd_sat_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_kind = '0;
  logic [1:0]  lane_mode = '0;
  logic        sat_en = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  shamt_imm = '0;
  logic        ctl_wr_en = 1'b0;
  logic [4:0]  ctl_wr_data = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        ctl_carry;
  logic [3:0]  ctl_ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit       exp_carry = 0;
  bit [3:0] exp_ovf = '0;

  always #4 clk = ~clk;

  simd_sat_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .lane_mode(lane_mode), .sat_en(sat_en), .op_a(op_a), .op_b(op_b),
    .shamt_imm(shamt_imm), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .out_valid(out_valid), .result(result), .ctl_carry(ctl_carry), .ctl_ovf(ctl_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lane model: signed value range arithmetic in 64-bit integers
  task automatic ref_arith(input int w, input int fn, input bit s,
                           input logic [31:0] ua, input logic [31:0] ub,
                           output logic [31:0] r, output bit cl);
    longint one = 1;
    longint av, bv, t, mx, mn;
    av = longint'(ua) & ((one << w) - 1);
    bv = longint'(ub) & ((one << w) - 1);
    if (av >= (one << (w - 1))) av = av - (one << w);
    if (bv >= (one << (w - 1))) bv = bv - (one << w);
    mx = (one << (w - 1)) - 1;
    mn = -(one << (w - 1));
    if (fn == 0) t = av + bv;
    else if (fn == 1) t = av - bv;
    else t = (av < 0) ? -av : av;
    cl = 0;
    if (s && (t > mx || t < mn)) begin
      cl = 1;
      t = (t > mx) ? mx : mn;
    end
    r = 32'(t & ((one << w) - 1));
  endtask

  task automatic ref_op(input int k, input int m, input bit s,
                        input logic [31:0] a, input logic [31:0] b, input logic [3:0] imm,
                        output logic [31:0] r, output bit [3:0] cl);
    longint one = 1;
    r = '0;
    cl = '0;
    if (k <= 2) begin
      int n, w;
      n = (m == 1) ? 2 : (m == 2) ? 4 : 1;
      w = 32 / n;
      for (int i = 0; i < n; i++) begin
        logic [31:0] lr;
        bit lc;
        ref_arith(w, k, s, a >> (i * w), b >> (i * w), lr, lc);
        r = r | (lr << (i * w));
        cl[i] = lc;
      end
    end else if (k == 3 || k == 4) begin
      int amt;
      amt = (k == 3) ? int'(imm) : int'(b[3:0]);
      for (int i = 0; i < 2; i++) begin
        longint hv, t;
        hv = longint'(a[i*16 +: 16]);
        if (hv >= 32768) hv = hv - 65536;
        t = hv * (one << amt);
        if (s && (t > 32767 || t < -32768)) begin
          cl[i] = 1;
          t = (hv < 0) ? -32768 : 32767;
        end
        r[i*16 +: 16] = 16'(t & 65535);
      end
    end else if (k == 5) begin
      longint sum;
      sum = longint'(a) + longint'(b);
      r = 32'(sum);
    end else if (k == 6) begin
      r = a + b + {31'd0, exp_carry};
    end
  endtask

  task automatic run_op(input string req, input int k, input int m, input bit s,
                        input logic [31:0] a, input logic [31:0] b, input logic [3:0] imm);
    logic [31:0] er;
    bit [3:0] ecl;
    ref_op(k, m, s, a, b, imm, er, ecl);
    if (k == 5) exp_carry = ((longint'(a) + longint'(b)) >> 32) != 0;
    exp_ovf = exp_ovf | ecl;
    @(negedge clk);
    in_valid = 1; op_kind = 3'(k); lane_mode = 2'(m); sat_en = s;
    op_a = a; op_b = b; shamt_imm = imm;
    @(negedge clk);
    in_valid = 0;
    check({req, " result"}, result, er);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " ovf"}, {28'd0, ctl_ovf}, {28'd0, exp_ovf});
    check({req, " carry"}, {31'd0, ctl_carry}, {31'd0, exp_carry});
  endtask

  task automatic write_ctl(input logic [4:0] d);
    @(negedge clk);
    ctl_wr_en = 1; ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 0;
    exp_carry = d[0];
    exp_ovf = d[4:1];
    check("R12 write", {27'd0, ctl_ovf, ctl_carry}, {27'd0, d});
  endtask

  task automatic test_reset();
    repeat (2) @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 ctl", {27'd0, ctl_ovf, ctl_carry}, 32'd0);
    rst_n = 1;
  endtask

  task automatic test_latency();
    logic [31:0] held;
    run_op("R2 add", 0, 0, 0, 32'h1234_0000, 32'h0000_5678, 4'd0);
    held = result;
    @(negedge clk);
    check("R2 idle valid low", {31'd0, out_valid}, 32'd0);
    check("R2 idle result held", result, held);
  endtask

  task automatic test_word();
    run_op("R3 wrap add", 0, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 4'd0);
    run_op("R3 sat add pos", 0, 0, 1, 32'h7FFF_FFFF, 32'h0000_0001, 4'd0);
    run_op("R3 sat sub neg", 1, 0, 1, 32'h8000_0000, 32'h0000_0001, 4'd0);
    run_op("R3 sat sub in range", 1, 0, 1, 32'h0000_0010, 32'h0000_0020, 4'd0);
    write_ctl(5'd0);
  endtask

  task automatic test_pair();
    run_op("R4 sat add one half", 0, 1, 1, 32'h7FFF_0001, 32'h0001_0002, 4'd0);
    run_op("R4 sat sub low half", 1, 1, 1, 32'h0005_8000, 32'h0003_0001, 4'd0);
    run_op("R4 wrap add halves", 0, 1, 0, 32'h7FFF_FFFF, 32'h0001_0001, 4'd0);
    write_ctl(5'd0);
  endtask

  task automatic test_quad();
    run_op("R5 sat add bytes", 0, 2, 1, 32'h7F10_80F0, 32'h0110_FFF0, 4'd0);
    run_op("R5 sat sub bytes", 1, 2, 1, 32'h807F_1000, 32'h01FF_2001, 4'd0);
    run_op("R5 wrap sub bytes", 1, 2, 0, 32'h807F_1000, 32'h01FF_2001, 4'd0);
    write_ctl(5'd0);
  endtask

  task automatic test_abs();
    run_op("R6 abs word min sat", 2, 0, 1, 32'h8000_0000, 32'h0, 4'd0);
    run_op("R6 abs word min wrap", 2, 0, 0, 32'h8000_0000, 32'h0, 4'd0);
    run_op("R6 abs halves", 2, 1, 1, 32'h8000_FFFE, 32'h0, 4'd0);
    run_op("R6 abs bytes", 2, 2, 0, 32'h80FF_7F01, 32'h0, 4'd0);
    write_ctl(5'd0);
  endtask

  task automatic test_shift();
    run_op("R7 shift imm zero", 3, 0, 1, 32'h8001_7FFF, 32'h0, 4'd0);
    run_op("R7 shift reg junk upper", 4, 0, 0, 32'h0011_0101, 32'hFFFF_FFF3, 4'd9);
    run_op("R8 shift sat mixed", 3, 0, 1, 32'h0001_C000, 32'h0, 4'd2);
    run_op("R8 shift sat pos", 4, 0, 1, 32'h4000_0003, 32'h0000_0001, 4'd0);
    run_op("R8 shift wrap", 3, 0, 0, 32'h0001_C000, 32'h0, 4'd2);
    write_ctl(5'd0);
  endtask

  task automatic test_carry();
    run_op("R9 addc no carry", 5, 0, 0, 32'h0000_0001, 32'h0000_0002, 4'd0);
    run_op("R9 addc carry", 5, 0, 0, 32'hF000_0000, 32'h2000_0000, 4'd0);
    run_op("R9 sat add keeps carry", 0, 0, 1, 32'h1, 32'h1, 4'd0);
    run_op("R10 addwc uses carry", 6, 0, 0, 32'h0000_0010, 32'h0000_0020, 4'd0);
    write_ctl(5'd0);
    // back-to-back 64-bit add: 0x1_FFFFFFFF + 0x2_00000001 = 0x4_00000000
    @(negedge clk);
    in_valid = 1; op_kind = 3'd5; sat_en = 0; lane_mode = 0;
    op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0001;
    @(negedge clk);
    op_kind = 3'd6; op_a = 32'h0000_0001; op_b = 32'h0000_0002;
    check("R10 chain low word", result, 32'h0000_0000);
    check("R9 chain carry", {31'd0, ctl_carry}, 32'd1);
    @(negedge clk);
    in_valid = 0;
    check("R10 chain high word", result, 32'h0000_0004);
    exp_carry = 1;
    write_ctl(5'd0);
  endtask

  task automatic test_flags();
    run_op("R11 set lane2", 0, 2, 1, 32'h0070_0000, 32'h0070_0000, 4'd0);
    run_op("R11 wrap leaves flags", 0, 2, 0, 32'h7F7F_7F7F, 32'h7F7F_7F7F, 4'd0);
    run_op("R11 sticky add lane0", 0, 1, 1, 32'h0000_7FFF, 32'h0000_7FFF, 4'd0);
    // write in same cycle as a clamping op: write wins
    @(negedge clk);
    in_valid = 1; op_kind = 3'd0; lane_mode = 2'd2; sat_en = 1;
    op_a = 32'h7F7F_7F7F; op_b = 32'h0101_0101;
    ctl_wr_en = 1; ctl_wr_data = 5'b01001;
    @(negedge clk);
    in_valid = 0; ctl_wr_en = 0;
    check("R12 write beats update", {27'd0, ctl_ovf, ctl_carry}, 32'h0000_0009);
    check("R12 op result unaffected", result, 32'h7F7F_7F7F);
    exp_ovf = 4'b0100; exp_carry = 1;
    write_ctl(5'd0);
  endtask

  initial begin
    test_reset();
    test_latency();
    test_word();
    test_pair();
    test_quad();
    test_abs();
    test_shift();
    test_carry();
    test_flags();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule